// File: doc/BRIEF.md
# NCO Baud Tick Generator

This block produces the bit-rate timing for a serial transmitter. It does not use an integer divide-by-N counter. A 16-bit increment, taken from the upper half of a 32-bit control word, is added every system clock to a 20-bit phase accumulator. Each time the accumulator wraps, the block emits a one-cycle bit tick. The long-run tick rate is therefore `increment × f_clk / 2^20`, and fractional ratios come at no extra cost.

The same block counts the bit ticks into frames of ten. It raises a one-cycle character-done strobe on every tenth tick, which gives the transmitter the length of one character. Bit 0 of the control word gates all of this activity. The block takes no part in serialising data. A new increment can be written at any time. It applies from the next clock and keeps the current phase.

Top module: `nco_baud_gen`

## Requirements
- R1: While `rst_ni` is low, `bit_tick_o` and `char_done_o` are 0, and the phase accumulator and the tick counter are cleared. With the increment N = 0x8000 and bit 0 held at 1, the first tick after reset release comes exactly 32 clock edges later.
- R2: The increment N is `ctrl_i[31:16]`. Consider K clock edges that start with the phase at zero and keep N constant. Over those edges, `bit_tick_o` is high for exactly floor(K·N / 2^20) cycles. Each tick is registered, so it appears in the cycle after the edge at which the 20-bit accumulator carries.
- R3: `bit_tick_o` is never high for two consecutive cycles, because N is below 2^19.
- R4: `char_done_o` is high in the same cycle as every tenth `bit_tick_o`, counted since the counter was last cleared, and is high at no other time. Over any run starting from a cleared counter, the strobe count equals floor(ticks / 10).
- R5: A change of N takes effect at the next clock edge without a reset and keeps the accumulated phase. After K1 edges at N1 followed by K2 edges at N2, the tick count is floor((K1·N1 + K2·N2) / 2^20).
- R6: With N = 0, no `bit_tick_o` and no `char_done_o` occur.
- R7: `ctrl_i[0]` is the transmit enable. At each clock edge where it is sampled low, the accumulator, the tick register and the tick counter are cleared, so no tick follows such an edge. When the bit returns to 1, timing restarts from zero phase.
- R8: `ctrl_i[15:1]`, which includes the receive-enable bit at bit 1, has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: [31:16] increment N, [0] transmit enable, [1] receive enable (not used here) |
| bit_tick_o | output | 1 | One-cycle pulse per bit period |
| char_done_o | output | 1 | One-cycle pulse on every tenth bit tick |

## Verification
The bench builds the block with its default parameters: a 20-bit accumulator, a 16-bit increment field at bits 31:16, and a ten-bit frame. With these values, an increment near 0xFFFF ticks roughly once every 16 clocks, so several hundred bit periods and dozens of character strobes fit in a few thousand cycles. Small increments show the zero-tick region, and 0x8000 makes the wrap point an exact 32 cycles. The expected tick and strobe counts come from integer arithmetic on K·N / 2^20, and the bench checks them for fixed increments, for an increment change in mid-run, and for runs with the unused control bits set.

// File: rtl/nco_baud_pkg.sv
package nco_baud_pkg;
  localparam int unsigned CtrlWDef      = 32;
  localparam int unsigned NcoLsbDef     = 16;
  localparam int unsigned NcoWDef       = 16;
  localparam int unsigned AccWDef       = 20;
  localparam int unsigned TxEnBitDef    = 0;
  localparam int unsigned FrameBitsDef  = 10;

  typedef struct packed {
    logic bit_tick;
    logic char_done;
  } baud_evt_t;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned NCO_W = 16,
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [NCO_W-1:0] inc_i,
  output logic             tick_o
);
  localparam int unsigned SumW = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SumW-1:0]  sum;
  logic             tick_q;

  assign sum    = {1'b0, acc_q} + SumW'(inc_i);
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end
  end

  // R7
  halted_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_q);

  // R6
  zero_inc_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && inc_i == '0) |=> !tick_q);

  generate
    if (NCO_W < ACC_W) begin : g_pulse_chk
      // R3
      single_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CntW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CntW-1:0] Last = CntW'(FRAME_BITS - 1);

  logic [CntW-1:0] cnt_q;
  logic            at_last;

  assign at_last = (cnt_q == Last);
  assign done_o  = tick_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Last);

  // R4
  wrap_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> cnt_q == '0);
endmodule

// File: rtl/nco_baud_gen.sv
module nco_baud_gen
  import nco_baud_pkg::*;
#(
  parameter int unsigned CTRL_W     = CtrlWDef,
  parameter int unsigned NCO_LSB    = NcoLsbDef,
  parameter int unsigned NCO_W      = NcoWDef,
  parameter int unsigned ACC_W      = AccWDef,
  parameter int unsigned TXEN_BIT   = TxEnBitDef,
  parameter int unsigned FRAME_BITS = FrameBitsDef
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              bit_tick_o,
  output logic              char_done_o
);
  logic [NCO_W-1:0]  nco_inc;
  logic              tx_en;
  logic              tick;
  logic              done;
  baud_evt_t         evt;
  logic [CTRL_W-1:0] ctrl_unused;

  assign nco_inc     = ctrl_i[NCO_LSB +: NCO_W];
  assign tx_en       = ctrl_i[TXEN_BIT];
  assign ctrl_unused = ctrl_i;

  nco_phase_acc #(
    .NCO_W (NCO_W),
    .ACC_W (ACC_W)
  ) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tx_en),
    .inc_i  (nco_inc),
    .tick_o (tick)
  );

  frame_counter #(
    .FRAME_BITS (FRAME_BITS)
  ) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (tx_en),
    .tick_i (tick),
    .done_o (done)
  );

  assign evt.bit_tick  = tick;
  assign evt.char_done = done;
  assign bit_tick_o    = evt.bit_tick;
  assign char_done_o   = evt.char_done;

  // R6
  tick_needs_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> $past(nco_inc != '0 && tx_en));

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!bit_tick_o && !char_done_o));
endmodule

// File: tb/sim_nco_baud_gen.sv
module sim_nco_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [15:0] VEC_NCO [NVEC] = '{16'hFFFF, 16'h8000, 16'h0001,
                                             16'h1234, 16'hC351, 16'h0000};
  localparam int VEC_CYC [NVEC] = '{2000, 1000, 3000, 5000, 4000, 500};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        tick, done;
  int          n_chk = 0;
  int          n_fail = 0;

  nco_baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
    .bit_tick_o(tick), .char_done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_ticks(input longint phase_sum);
    return phase_sum >> 20;
  endfunction

  // runs k edges, counts ticks, strobes and strobes without tick, back-to-back ticks
  task automatic run(input int k, output int t, output int c, output int bad, output int dbl);
    logic prev = 1'b0;
    t = 0; c = 0; bad = 0; dbl = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (tick) t++;
      if (done) c++;
      if (done && !tick) bad++;
      if (tick && prev) dbl++;
      prev = tick;
    end
  endtask

  task automatic restart(input logic [15:0] n, input logic [14:0] spare);
    @(negedge clk);
    ctrl = {n, spare, 1'b0};
    @(negedge clk);
    ctrl = {n, spare, 1'b1};
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t, c, bad, dbl, t2, c2;
    ctrl = {16'h8000, 15'h0, 1'b1};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tick in reset", tick, 0);
    check("R1 strobe in reset", done, 0);
    rst_n = 1'b1;
    // R1: first tick exactly at edge 32 after release
    run(31, t, c, bad, dbl);
    check("R1 no tick before edge 32", t, 0);
    @(negedge clk);
    check("R1 tick at edge 32", tick, 1);

    // table-driven R2/R3/R4/R6
    for (int v = 0; v < NVEC; v++) begin
      restart(VEC_NCO[v], 15'h0);
      run(VEC_CYC[v], t, c, bad, dbl);
      check($sformatf("R2 ticks nco=%h", VEC_NCO[v]), t,
            exp_ticks(longint'(VEC_CYC[v]) * VEC_NCO[v]));
      check($sformatf("R4 strobes nco=%h", VEC_NCO[v]), c,
            exp_ticks(longint'(VEC_CYC[v]) * VEC_NCO[v]) / 10);
      check("R4 strobe without tick", bad, 0);
      check("R3 back-to-back ticks", dbl, 0);
      if (VEC_NCO[v] == 16'h0) check("R6 zero increment ticks", t + c, 0);
    end

    // R5: change increment mid-run, phase kept
    restart(16'h3000, 15'h0);
    run(777, t, c, bad, dbl);
    ctrl = {16'hE001, 15'h0, 1'b1};
    run(1500, t2, c2, bad, dbl);
    check("R5 ticks across change", t + t2,
          exp_ticks(777 * 64'h3000 + 1500 * 64'hE001));
    check("R5 strobes across change", c + c2,
          exp_ticks(777 * 64'h3000 + 1500 * 64'hE001) / 10);

    // R7: enable low blocks ticks
    @(negedge clk);
    ctrl = {16'hFFFF, 15'h0, 1'b0};
    run(300, t, c, bad, dbl);
    check("R7 ticks while disabled", t + c, 0);
    // R7: restart from zero phase (0x8000 -> edge 32)
    ctrl = {16'h8000, 15'h0, 1'b1};
    run(31, t, c, bad, dbl);
    check("R7 no early tick after enable", t, 0);
    @(negedge clk);
    check("R7 tick at edge 32 after enable", tick, 1);

    // R8: spare bits incl. receive enable have no effect
    restart(16'hFFFF, 15'h7FFF);
    run(2000, t, c, bad, dbl);
    check("R8 ticks with spare bits set", t, exp_ticks(2000 * 64'hFFFF));
    check("R8 strobes with spare bits set", c, exp_ticks(2000 * 64'hFFFF) / 10);
    restart(16'h0000, 15'h0001);
    run(400, t, c, bad, dbl);
    check("R8 receive enable alone", t + c, 0);

    // R1: reset mid-run clears phase
    restart(16'h8000, 15'h0);
    run(20, t, c, bad, dbl);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 tick during mid-run reset", tick, 0);
    rst_n = 1'b1;
    run(31, t, c, bad, dbl);
    check("R1 phase cleared by reset", t, 0);
    @(negedge clk);
    check("R1 tick at edge 32 after reset", tick, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule